// File: doc/BRIEF.md
# Output Shutdown Request Detector

This block watches a single active-low emergency input and latches a shutdown request flag when a fault shows up on it. The fault condition is selectable. It can be a falling edge seen on every clock, or a low level that persists across sampling strobes taken at one of three divided clock rates. The divided strobes are generated inside the block.

Software reaches the block through one 16-bit control/status register on a simple request/write-enable bus. The register holds the request flag, a high-impedance enable, an interrupt enable and the two mode bits. The flag drives two outputs. A tri-state command goes to the output pin drivers when the flag and the high-impedance enable are both 1. An interrupt request goes out when the flag and the interrupt enable are both 1. Software cannot set the flag. It clears the flag with a read that returns the flag as 1, followed by a write of 0 to the flag bit. In a level mode that clear also waits until the pin has been sampled high at the selected rate.

Top module: `shd_detector`

## Requirements
- R1: After reset, bus_rdata_o reads 0x0000, and hiz_o and irq_o are low.
- R2: The flag (bit 12) is set only by the selected pin condition. A write with bit 12 = 1 never sets it.
- R3: Bits 15:13, 11:10 and 7:2 always read 0, and writing 1 to them has no visible effect.
- R4: In edge mode (bits 1:0 = 00), a write with bit 12 = 0 clears the flag only if the bus access just before it was a read that returned the flag as 1. Any write clears that armed state, including one with bit 12 = 1.
- R5: In a level mode, the read-1-then-write-0 clear is refused until a high pin level has been sampled on a strobe of the selected rate after the flag was last set.
- R6: Mode 01 samples every 8 clocks, 10 every 16 and 11 every 128. The flag sets on the 16th consecutive low sample, and a high sample restarts the count.
- R7: The pin passes through a two-flop synchronizer. In edge mode, a falling edge on pin_ni before clock edge k sets the flag at edge k+2.
- R8: hiz_o is high exactly when the flag and bit 9 are both 1.
- R9: irq_o is high exactly when the flag and bit 8 are both 1.
- R10: When a set condition and a valid clear fall in the same cycle, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_ni | input | 1 | Emergency input, active low, asynchronous |
| bus_req_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Register contents |
| hiz_o | output | 1 | Tri-state command to the output pins |
| irq_o | output | 1 | Interrupt request |

## Verification
A new set condition from the pin and a software clear can arrive in the same cycle, so the two collide. The bench arms a clear by reading the flag as 1. It then drops the pin at several offsets so that the synchronized falling edge comes one cycle before, in the same cycle as, and after the clearing write. A cycle-accurate behavioural model predicts the flag on every clock. An explicit check confirms that at the coinciding offset the flag is still 1 after the write.

// File: rtl/shd_pkg.sv
package shd_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned FLAG_BIT = 12;
  localparam int unsigned HIZ_BIT  = 9;
  localparam int unsigned IRQ_BIT  = 8;

  typedef enum logic [1:0] {
    MODE_EDGE  = 2'b00,
    MODE_DIV_A = 2'b01,
    MODE_DIV_B = 2'b10,
    MODE_DIV_C = 2'b11
  } det_mode_e;
endpackage

// File: rtl/shd_strobe_gen.sv
module shd_strobe_gen #(
  parameter int unsigned DIV_A = 8,
  parameter int unsigned DIV_B = 16,
  parameter int unsigned DIV_C = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [2:0] stb_o
);
  localparam int unsigned DIV_AB  = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int unsigned DIV_MAX = (DIV_AB > DIV_C) ? DIV_AB : DIV_C;
  localparam int unsigned CW      = $clog2(DIV_MAX);

  function automatic int unsigned div_of(int k);
    case (k)
      0:       return DIV_A;
      1:       return DIV_B;
      default: return DIV_C;
    endcase
  endfunction

  for (genvar k = 0; k < 3; k++) begin : g_div
    localparam int unsigned D = div_of(k);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   cnt_q <= '0;
      else if (cnt_q == CW'(D - 1))  cnt_q <= '0;
      else                           cnt_q <= cnt_q + 1'b1;
    end

    assign stb_o[k] = (cnt_q == CW'(D - 1));
  end
endmodule

// File: rtl/shd_pin_detect.sv
module shd_pin_detect
  import shd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LOW_RUN     = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pin_ni,
  input  det_mode_e mode_i,
  input  logic [2:0] stb_i,
  output logic      set_ev_o,
  output logic      hi_seen_o
);
  localparam int unsigned RW = $clog2(LOW_RUN);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pin_s;
  logic                   fall;
  logic                   stb_sel;
  logic                   lvl_hit;
  logic [RW-1:0]          run_q;
  logic                   hi_seen_q;

  // idle level is high, so reset to 1 to avoid a false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_ni};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign pin_s = sync_q[SYNC_STAGES-1];
  assign fall  = prev_q & ~pin_s;

  always_comb begin
    case (mode_i)
      MODE_DIV_A: stb_sel = stb_i[0];
      MODE_DIV_B: stb_sel = stb_i[1];
      MODE_DIV_C: stb_sel = stb_i[2];
      default:    stb_sel = 1'b0;
    endcase
  end

  assign lvl_hit = stb_sel & ~pin_s & (run_q == RW'(LOW_RUN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            run_q <= '0;
    else if (mode_i == MODE_EDGE)           run_q <= '0;
    else if (stb_sel) begin
      if (pin_s)                            run_q <= '0;
      else if (run_q != RW'(LOW_RUN - 1))   run_q <= run_q + 1'b1;
    end
  end

  assign set_ev_o = (mode_i == MODE_EDGE) ? fall : lvl_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          hi_seen_q <= 1'b0;
    else if (set_ev_o)                                    hi_seen_q <= 1'b0;
    else if (mode_i != MODE_EDGE && stb_sel && pin_s)     hi_seen_q <= 1'b1;
  end

  assign hi_seen_o = hi_seen_q;

  AST_LVL_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_EDGE && set_ev_o) |-> stb_sel); // R6
endmodule

// File: rtl/shd_ctrl_reg.sv
module shd_ctrl_reg
  import shd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  input  logic             set_ev_i,
  input  logic             hi_seen_i,
  output logic [REG_W-1:0] bus_rdata_o,
  output det_mode_e        mode_o,
  output logic             hiz_o,
  output logic             irq_o
);
  logic      flag_q;
  logic      hiz_en_q;
  logic      irq_en_q;
  logic      armed_q;
  det_mode_e mode_q;
  logic      rd_fire;
  logic      wr_fire;
  logic      clr_ok;
  logic      unused_wdata;

  assign rd_fire = bus_req_i & ~bus_we_i;
  assign wr_fire = bus_req_i & bus_we_i;
  assign clr_ok  = wr_fire & ~bus_wdata_i[FLAG_BIT] & armed_q &
                   ((mode_q == MODE_EDGE) | hi_seen_i);

  // arm on a read that returns the flag as 1; any write disarms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 armed_q <= 1'b0;
    else if (wr_fire)            armed_q <= 1'b0;
    else if (rd_fire && flag_q)  armed_q <= 1'b1;
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (set_ev_i) flag_q <= 1'b1;
    else if (clr_ok)   flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hiz_en_q <= 1'b0;
      irq_en_q <= 1'b0;
      mode_q   <= MODE_EDGE;
    end else if (wr_fire) begin
      hiz_en_q <= bus_wdata_i[HIZ_BIT];
      irq_en_q <= bus_wdata_i[IRQ_BIT];
      mode_q   <= det_mode_e'(bus_wdata_i[1:0]);
    end
  end

  always_comb begin
    bus_rdata_o           = '0;
    bus_rdata_o[FLAG_BIT] = flag_q;
    bus_rdata_o[HIZ_BIT]  = hiz_en_q;
    bus_rdata_o[IRQ_BIT]  = irq_en_q;
    bus_rdata_o[1:0]      = mode_q;
  end

  assign unused_wdata = ^{bus_wdata_i[15:13], bus_wdata_i[11:10], bus_wdata_i[7:2]};

  assign mode_o = mode_q;
  assign hiz_o  = flag_q & hiz_en_q;
  assign irq_o  = flag_q & irq_en_q;

  AST_FLAG_FROM_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(set_ev_i)); // R2
  AST_CLR_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(armed_q && wr_fire && !bus_wdata_i[FLAG_BIT])); // R4
  AST_LVL_CLR_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(flag_q) && $past(mode_q != MODE_EDGE)) |-> $past(hi_seen_i)); // R5
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_ev_i |=> flag_q); // R10
endmodule

// File: rtl/shd_detector.sv
module shd_detector
  import shd_pkg::*;
#(
  parameter int unsigned DIV_A       = 8,
  parameter int unsigned DIV_B       = 16,
  parameter int unsigned DIV_C       = 128,
  parameter int unsigned LOW_RUN     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pin_ni,
  input  logic        bus_req_i,
  input  logic        bus_we_i,
  input  logic [15:0] bus_wdata_i,
  output logic [15:0] bus_rdata_o,
  output logic        hiz_o,
  output logic        irq_o
);
  logic [2:0] stb;
  logic       set_ev;
  logic       hi_seen;
  det_mode_e  mode;

  shd_strobe_gen #(
    .DIV_A(DIV_A),
    .DIV_B(DIV_B),
    .DIV_C(DIV_C)
  ) i_strobe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stb_o (stb)
  );

  shd_pin_detect #(
    .SYNC_STAGES(SYNC_STAGES),
    .LOW_RUN    (LOW_RUN)
  ) i_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_ni   (pin_ni),
    .mode_i   (mode),
    .stb_i    (stb),
    .set_ev_o (set_ev),
    .hi_seen_o(hi_seen)
  );

  shd_ctrl_reg i_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_req_i  (bus_req_i),
    .bus_we_i   (bus_we_i),
    .bus_wdata_i(bus_wdata_i),
    .set_ev_i   (set_ev),
    .hi_seen_i  (hi_seen),
    .bus_rdata_o(bus_rdata_o),
    .mode_o     (mode),
    .hiz_o      (hiz_o),
    .irq_o      (irq_o)
  );

  AST_OUT_NEED_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hiz_o || irq_o) |-> bus_rdata_o[FLAG_BIT]); // R8
endmodule

// File: tb/test_shd_detector.sv
`timescale 1ns/1ps
module test_shd_detector;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pin_ni = 1'b1;
  logic        bus_req_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic        hiz_o;
  logic        irq_o;

  always #2.5 clk_i = ~clk_i;

  shd_detector i_shd_detector (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_ni(pin_ni),
    .bus_req_i(bus_req_i), .bus_we_i(bus_we_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .hiz_o(hiz_o), .irq_o(irq_o)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit       m_flag, m_hiz, m_irq, m_armed, m_hiseen;
  bit [1:0] m_mode;
  bit       q1, q2, q3;
  int       lowcnt, cyc;

  function automatic int div_of(bit [1:0] m);
    case (m)
      2'd1:    return 8;
      2'd2:    return 16;
      default: return 128;
    endcase
  endfunction

  function automatic logic [15:0] exp_rd();
    return {3'b000, m_flag, 2'b00, m_hiz, m_irq, 6'b0, m_mode};
  endfunction

  task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_flag = 0; m_hiz = 0; m_irq = 0; m_armed = 0; m_hiseen = 0; m_mode = 0;
      q1 = 1; q2 = 1; q3 = 1; lowcnt = 0; cyc = 0;
    end else begin
      bit rd_f, wr_f, stb, set_ev, clr;
      rd_f = bus_req_i && !bus_we_i;
      wr_f = bus_req_i && bus_we_i;
      stb  = (m_mode != 0) && ((cyc % div_of(m_mode)) == div_of(m_mode) - 1);
      if (m_mode == 0) set_ev = q3 && !q2;
      else             set_ev = stb && !q2 && (lowcnt == 15);
      clr = wr_f && !bus_wdata_i[12] && m_armed && (m_mode == 0 || m_hiseen);
      if (set_ev) m_hiseen = 0;
      else if (m_mode != 0 && stb && q2) m_hiseen = 1;
      if (m_mode == 0) lowcnt = 0;
      else if (stb) begin
        if (q2) lowcnt = 0;
        else if (lowcnt < 15) lowcnt++;
      end
      if (wr_f) m_armed = 0;
      else if (rd_f && m_flag) m_armed = 1;
      if (set_ev) m_flag = 1;
      else if (clr) m_flag = 0;
      if (wr_f) begin
        m_hiz = bus_wdata_i[9]; m_irq = bus_wdata_i[8]; m_mode = bus_wdata_i[1:0];
      end
      q3 = q2; q2 = q1; q1 = pin_ni;
      cyc++;
    end
    #1;
    chk(bus_rdata_o == exp_rd(), cur_req, bus_rdata_o, exp_rd());
    chk(hiz_o == (m_flag & m_hiz), "R8", {15'b0, hiz_o}, {15'b0, m_flag & m_hiz});
    chk(irq_o == (m_flag & m_irq), "R9", {15'b0, irq_o}, {15'b0, m_flag & m_irq});
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bus_wr(logic [15:0] d);
    @(negedge clk_i);
    bus_req_i = 1; bus_we_i = 1; bus_wdata_i = d;
    @(negedge clk_i);
    bus_req_i = 0; bus_we_i = 0; bus_wdata_i = '0;
  endtask

  task automatic bus_rd();
    @(negedge clk_i);
    bus_req_i = 1; bus_we_i = 0;
    @(negedge clk_i);
    bus_req_i = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    idle(3);
    chk(bus_rdata_o == 16'h0000, "R1", bus_rdata_o, 16'h0000);
    chk({hiz_o, irq_o} == 2'b00, "R1", {14'b0, hiz_o, irq_o}, 16'h0);
    rst_ni = 1;
    idle(2);

    cur_req = "R3";
    bus_wr(16'hEFFC); idle(2);
    chk(bus_rdata_o == 16'h0300, "R3", bus_rdata_o, 16'h0300);
    cur_req = "R2";
    bus_wr(16'h1300); idle(2);
    chk(bus_rdata_o[12] == 1'b0, "R2", bus_rdata_o, 16'h0300);

    cur_req = "R7";
    pin_ni = 0; idle(1);
    chk(bus_rdata_o[12] == 1'b0, "R7", bus_rdata_o, 16'h0300);
    idle(2);
    chk(bus_rdata_o[12] == 1'b1, "R7", bus_rdata_o, 16'h1300);
    chk(hiz_o == 1'b1, "R8", {15'b0, hiz_o}, 16'h1);
    chk(irq_o == 1'b1, "R9", {15'b0, irq_o}, 16'h1);

    cur_req = "R4";
    bus_wr(16'h0300); idle(2);
    chk(bus_rdata_o[12] == 1'b1, "R4", bus_rdata_o, 16'h1300);
    bus_rd(); bus_wr(16'h1300); bus_wr(16'h0300); idle(1);
    chk(bus_rdata_o[12] == 1'b1, "R4", bus_rdata_o, 16'h1300);
    bus_rd(); bus_wr(16'h0300); idle(1);
    chk(bus_rdata_o == 16'h0300, "R4", bus_rdata_o, 16'h0300);

    cur_req = "R9";
    bus_wr(16'h0200);
    pin_ni = 1; idle(4); pin_ni = 0; idle(4);
    chk(hiz_o == 1'b1 && irq_o == 1'b0, "R9", {14'b0, hiz_o, irq_o}, 16'h2);
    bus_rd(); bus_wr(16'h0100); idle(1);
    chk(bus_rdata_o == 16'h0100, "R8", bus_rdata_o, 16'h0100);

    cur_req = "R6";
    pin_ni = 1; idle(4);
    bus_wr(16'h0101);
    pin_ni = 0; idle(8 * 14);
    chk(bus_rdata_o[12] == 1'b0, "R6", bus_rdata_o, 16'h0101);
    idle(8 * 4);
    chk(bus_rdata_o[12] == 1'b1, "R6", bus_rdata_o, 16'h1101);

    cur_req = "R5";
    bus_rd(); bus_wr(16'h0101); idle(2);
    chk(bus_rdata_o[12] == 1'b1, "R5", bus_rdata_o, 16'h1101);
    pin_ni = 1; idle(30);
    bus_rd(); bus_wr(16'h0101); idle(1);
    chk(bus_rdata_o == 16'h0101, "R5", bus_rdata_o, 16'h0101);

    cur_req = "R6";
    pin_ni = 0; idle(8 * 10); pin_ni = 1; idle(8 * 2); pin_ni = 0; idle(8 * 10);
    chk(bus_rdata_o[12] == 1'b0, "R6", bus_rdata_o, 16'h0101);
    pin_ni = 1; idle(20);

    bus_wr(16'h0102);
    pin_ni = 0; idle(16 * 18);
    chk(bus_rdata_o[12] == 1'b1, "R6", bus_rdata_o, 16'h1102);
    pin_ni = 1; idle(40);
    bus_rd(); bus_wr(16'h0103); idle(1);
    chk(bus_rdata_o == 16'h0103, "R5", bus_rdata_o, 16'h0103);
    pin_ni = 0; idle(128 * 14);
    chk(bus_rdata_o[12] == 1'b0, "R6", bus_rdata_o, 16'h0103);
    idle(128 * 4);
    chk(bus_rdata_o[12] == 1'b1, "R6", bus_rdata_o, 16'h1103);
    pin_ni = 1; idle(300);
    bus_rd(); bus_wr(16'h0100); idle(1);
    chk(bus_rdata_o == 16'h0100, "R5", bus_rdata_o, 16'h0100);

    cur_req = "R10";
    for (int off = 0; off < 4; off++) begin
      pin_ni = 0; idle(4); pin_ni = 1; idle(4);
      bus_rd();
      pin_ni = 0;
      idle(off);
      bus_wr(16'h0100);
      if (off == 1)
        chk(bus_rdata_o[12] == 1'b1, "R10", bus_rdata_o, 16'h1100);
      idle(3);
      pin_ni = 1; idle(4);
    end

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end
endmodule